// File: doc/BRIEF.md
# Two-Phase Carrier Generator with Modulation Gating

This block builds a carrier clock for infrared remote-control transmitters. An 8-bit counter runs on a prescaled count enable. It compares against two compare values in turn. The first interval after a start uses compare 0 and the next uses compare 1, so the two phases of the carrier can be set independently. Each match clears the counter, swaps the active compare value and raises a timer interrupt pulse.

A second counter measures the modulation period on the same count enable. When it matches its period value, an event is held pending until the next count tick. That aligns the event to the carrier timer, which then emits a period interrupt and copies a software-written buffer bit into the active modulation bit. The carrier reaches the output pin only while that active bit is high. Software therefore writes the next bit, and the next period value, after each period interrupt.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset `carrier_out`, `tmr_irq` and `period_irq` are 0, and the active modulation bit is 0.
- R2: Writes decode `wr_addr` as follows. Address 0 is the mode byte: bit 7 run, bits 5:3 clock select, bit 2 carrier mode, bit 1 idle level, bit 0 output enable. Address 1 is compare 0 and address 2 is compare 1. Address 3 is the modulation control byte: bit 0 buffered modulation bit, bit 1 remote output enable. Address 4 is the period value. Writes to addresses 5 to 7 change nothing.
- R3: While running, a count tick occurs once every 2^S clock cycles, where S is the clock select. The first tick comes 2^S cycles after the edge that sets run.
- R4: After a start the first interval uses compare 0. A compare value N spans N+1 ticks, so the first phase change appears (N+1)*2^S cycles after the start edge.
- R5: On a tick where the counter equals the active compare value, the counter clears and the other compare value becomes active. `tmr_irq` is high for the cycle after that tick.
- R6: With gating open, `carrier_out` equals the idle level during compare-0 intervals and its inverse during compare-1 intervals.
- R7: `carrier_out` equals the idle level unless run, output enable, carrier mode, remote output enable and the active modulation bit are all 1.
- R8: The period counter spans P+1 ticks for a period value P. Its match is held pending until the next tick. That tick raises `period_irq` for one cycle and loads the buffered bit into the active modulation bit.
- R9: A write to the buffered modulation bit does not change `carrier_out` before the next period transfer.
- R10: Clearing run resets the prescaler, both counters, the pending event and the active compare select to compare 0. The active modulation bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write data |
| carrier_out | output | 1 | Gated carrier pin |
| tmr_irq | output | 1 | Compare match pulse |
| period_irq | output | 1 | Synchronized period event pulse |

## Verification
Directed starts with unequal compare values and a non-zero clock select measure the low and high phase lengths in cycles. A swap of the compare values, or an off-by-one in the interval or prescaler, changes those counts. Separate cases toggle the buffered bit against a long period, and clear the remote enable. These show whether the buffer leaks to the pin early and whether every gating term is honoured. Random runs then mix small compare and period values, including zero, with all clock selects 0 to 2. They also issue writes while counting, including to unused addresses. Every output is compared cycle by cycle with a bench model, which exposes timing slips of the pending transfer and of the compare swap.

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
  parameter int W  = 8,
  parameter int PW = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       carrier_out,
  output logic       tmr_irq,
  output logic       period_irq
);
  logic [7:0]    mode_q, ctl_q;
  logic [W-1:0]  cmp0_q, cmp1_q, per_q, cnt_q, pcnt_q;
  logic [PW-1:0] pre_q;
  logic          sel_q, pend_q, nrz_q, tirq_q, pirq_q;

  wire run     = mode_q[7];
  wire out_en  = mode_q[0];
  wire idle    = mode_q[1];
  wire cmode   = mode_q[2];
  wire nrz_buf = ctl_q[0];
  wire rmt_en  = ctl_q[1];

  wire [PW-1:0] mask   = ~({PW{1'b1}} << mode_q[5:3]);
  wire          tick   = run && ((pre_q & mask) == mask);
  wire [W-1:0]  active = sel_q ? cmp1_q : cmp0_q;
  wire          hit    = tick && (cnt_q == active);
  wire          phit   = tick && (pcnt_q == per_q);
  wire          xfer   = tick && pend_q;
  wire          gate   = run && out_en && cmode && rmt_en && nrz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctl_q  <= '0;
      cmp0_q <= '0;
      cmp1_q <= '0;
      per_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: mode_q <= wr_data;
        3'd1: cmp0_q <= W'(wr_data);
        3'd2: cmp1_q <= W'(wr_data);
        3'd3: ctl_q  <= wr_data;
        3'd4: per_q  <= W'(wr_data);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      pcnt_q <= '0;
      sel_q  <= 1'b0;
      pend_q <= 1'b0;
      tirq_q <= 1'b0;
      pirq_q <= 1'b0;
    end else if (!run) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      pcnt_q <= '0;
      sel_q  <= 1'b0;
      pend_q <= 1'b0;
      tirq_q <= 1'b0;
      pirq_q <= 1'b0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      tirq_q <= hit;
      pirq_q <= xfer;
      pend_q <= phit | (pend_q & ~tick);
      if (tick) begin
        cnt_q  <= hit  ? '0 : cnt_q + 1'b1;
        pcnt_q <= phit ? '0 : pcnt_q + 1'b1;
        sel_q  <= sel_q ^ hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nrz_q <= 1'b0;
    else if (xfer) nrz_q <= nrz_buf;
  end

  assign carrier_out = gate ? (idle ^ sel_q) : idle;
  assign tmr_irq     = tirq_q;
  assign period_irq  = pirq_q;

  // R10
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && !sel_q && !pend_q && pcnt_q == '0));

  // R4
  start_cmp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (!sel_q && cnt_q == '0));

  // R5
  match_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |-> (cnt_q == '0 && sel_q != $past(sel_q)));

  // R8
  nrz_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_irq |-> (nrz_q == $past(nrz_buf)));

  // R7
  gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nrz_q |-> (carrier_out == idle));
endmodule

// File: tb/ir_carrier_gen_test.sv
module ir_carrier_gen_test;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic carrier_out, tmr_irq, period_irq;
  int checks = 0, failures = 0;
  bit cmp_on = 0, done = 0;

  always #5 clk = ~clk;

  ir_carrier_gen uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .carrier_out(carrier_out), .tmr_irq(tmr_irq), .period_irq(period_irq));

  // bench model built from the requirements
  logic [7:0] m_mode, m_ctl, m_c0, m_c1, m_per, m_cnt, m_pcnt;
  logic [6:0] m_pre;
  logic m_sel, m_pend, m_nrz, m_tirq, m_pirq;

  function automatic logic [6:0] tick_mask(input logic [2:0] s);
    return ~(7'h7f << s);
  endfunction

  function automatic logic exp_pin(input logic [7:0] md, input logic [7:0] ct,
                                   input logic nrz, input logic sel);
    if (md[7] && md[0] && md[2] && ct[1] && nrz) return md[1] ^ sel;
    return md[1];
  endfunction

  function automatic int first_phase(input int n, input int s);
    return (n + 1) << s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_ctl <= 0; m_c0 <= 0; m_c1 <= 0; m_per <= 0;
      m_cnt <= 0; m_pcnt <= 0; m_pre <= 0;
      m_sel <= 0; m_pend <= 0; m_nrz <= 0; m_tirq <= 0; m_pirq <= 0;
    end else begin
      automatic logic tk = m_mode[7] && ((m_pre & tick_mask(m_mode[5:3])) == tick_mask(m_mode[5:3]));
      automatic logic ht = tk && (m_cnt == (m_sel ? m_c1 : m_c0));
      automatic logic ph = tk && (m_pcnt == m_per);
      // R2 decode
      if (wr_en) begin
        if (wr_addr == 0) m_mode <= wr_data;
        if (wr_addr == 1) m_c0 <= wr_data;
        if (wr_addr == 2) m_c1 <= wr_data;
        if (wr_addr == 3) m_ctl <= wr_data;
        if (wr_addr == 4) m_per <= wr_data;
      end
      if (tk && m_pend) m_nrz <= m_ctl[0];
      if (!m_mode[7]) begin
        m_pre <= 0; m_cnt <= 0; m_pcnt <= 0; m_sel <= 0;
        m_pend <= 0; m_tirq <= 0; m_pirq <= 0;
      end else begin
        m_pre <= m_pre + 1;
        m_tirq <= ht;
        m_pirq <= tk && m_pend;
        m_pend <= ph | (m_pend & ~tk);
        if (tk) begin
          m_cnt <= ht ? 8'd0 : m_cnt + 1;
          m_pcnt <= ph ? 8'd0 : m_pcnt + 1;
          m_sel <= m_sel ^ ht;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && !done) begin
    check("R6 R7 pin", carrier_out, exp_pin(m_mode, m_ctl, m_nrz, m_sel));
    check("R5 tmr_irq", tmr_irq, m_tirq);
    check("R8 period_irq", period_irq, m_pirq);
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int k, highs;
    void'($urandom(32'd20240611));
    #23 rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 pin", carrier_out, 0);
    check("R1 tmr_irq", tmr_irq, 0);
    check("R1 period_irq", period_irq, 0);
    cmp_on = 1;

    wr(1, 8'd3); wr(2, 8'd1); wr(4, 8'd0); wr(3, 8'h03);
    wr(0, 8'h85);
    idle_cycles(10);
    wr(0, 8'h05);
    idle_cycles(2);
    // R10: stopped, pin at idle level
    check("R10 stop idle", carrier_out, 0);

    // R3 R4: start with clock select 1
    wr(0, 8'h8D);
    k = 0;
    while (carrier_out == 0 && k < 100) begin @(negedge clk); k++; end
    check("R4 R3 first phase", k, first_phase(3, 1));
    k = 0;
    while (carrier_out == 1 && k < 100) begin @(negedge clk); k++; end
    check("R6 high phase", k, first_phase(1, 1));

    // R9: buffer cleared, long period keeps active bit
    wr(0, 8'h05); wr(4, 8'd200); wr(3, 8'h02); wr(0, 8'h85);
    highs = 0;
    repeat (40) begin @(negedge clk); highs += carrier_out; end
    check("R9 carrier kept", highs > 0, 1);
    idle_cycles(200);
    highs = 0;
    repeat (30) begin @(negedge clk); highs += carrier_out; end
    check("R8 transfer gates off", highs, 0);

    // R7: remote enable clear blocks carrier
    wr(4, 8'd0); wr(3, 8'h03); idle_cycles(5);
    wr(3, 8'h01);
    highs = 0;
    repeat (30) begin @(negedge clk); highs += carrier_out; end
    check("R7 remote off", highs, 0);

    // R2: unused addresses
    wr(3, 8'h03); wr(5, 8'hff); wr(6, 8'h00); wr(7, 8'h55);
    idle_cycles(20);

    for (int c = 0; c < 40; c++) begin
      wr(0, 8'h05);
      wr(1, 8'($urandom_range(0, 7)));
      wr(2, 8'($urandom_range(0, 7)));
      wr(4, 8'($urandom_range(0, 15)));
      wr(3, {6'd0, 1'b1, 1'($urandom_range(0, 1))});
      wr(0, {1'b1, 1'b0, 3'($urandom_range(0, 2)), 1'b1,
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 4) != 0)});
      for (int i = 0; i < 30; i++) begin
        idle_cycles($urandom_range(2, 12));
        case ($urandom_range(0, 4))
          0: wr(3, {6'd0, 1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 1))});
          1: wr(3'($urandom_range(5, 7)), 8'($urandom));
          2: wr(4, 8'($urandom_range(0, 15)));
          3: wr(1, 8'($urandom_range(0, 7)));
          default: wr(2, 8'($urandom_range(0, 7)));
        endcase
      end
    end
    finish_run();
  end
endmodule